// File: doc/BRIEF.md
# Multiple Single-Input-Change Scan Pattern Generator

This block feeds a set of parallel scan chains with low-transition test patterns in a test-per-scan flow. A reconfigurable twisted-ring (Johnson) counter with one stage per scan bit is combined with a slowly advancing LFSR seed through one XOR per chain. Before each scan load the counter takes one twisted-ring step. It then rotates once per shift cycle, so that every chain receives one rotation of the current counter vector, inverted or not by that chain's seed bit. Each load is followed by a single capture cycle.

The seed advances once every 2·CHAIN_LEN patterns. Successive loads of one chain under the same seed therefore differ in exactly one bit. After reset a clear phase forces the counter to zero. The run then proceeds until a programmable number of captures has been issued and `done_o` rises. One clock drives everything, and the slow seed clock is modelled as a step enable.

Top module: `msic_tpg`

## Requirements
- R1: While rst_ni is low, scan_data_o is all zero, shift_o, capture_o and done_o are 0, and scan_en_o is 1.
- R2: After reset the counter is cleared (shift-in of zeros for CHAIN_LEN+1 cycles), so the counter vector used by the first pattern is 0...01.
- R3: Before each load the counter takes one twisted-ring step, J' = {J[L-2:0], ~J[L-1]}, so a seed period walks through 2·L distinct vectors.
- R4: A load is L consecutive cycles with shift_o=1. On shift cycle k (from 0), bit j of scan_data_o equals R_k[j] ^ S[j], where R_0 is the stepped vector, R_{k+1} = {R_k[L-2:0], R_k[L-1]} and S is the current seed.
- R5: After each load of exactly L shift cycles comes one cycle with capture_o=1 and scan_en_o=0. At all other times scan_en_o is 1 and capture_o is 0.
- R6: The seed resets to SEED_INIT (nonzero), advances as S' = {S[W-2:0], ^(S & SEED_TAPS)} after every 2·L captures, and is never zero.
- R7: After pat_limit_i captures done_o rises and stays high, and no further shift or capture occurs. A limit of 0 gives done with no pattern.
- R8: Under one seed, the L-bit word shifted into a chain differs from that chain's previous word in exactly one bit.
- R9: Outputs are registered. scan_data_o changes only in cycles where shift_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pat_limit_i | input | PCNT_W | Number of patterns to apply; hold stable during a run |
| scan_data_o | output | NUM_CHAINS | Scan-in bit for each chain |
| shift_o | output | 1 | Chains shift scan_data_o in this cycle |
| scan_en_o | output | 1 | Scan enable, low only during capture |
| capture_o | output | 1 | Capture strobe |
| done_o | output | 1 | Pattern limit reached |

## Verification
The bench builds the block with four chains of length six and an 8-bit seed. With these values one seed period is only twelve patterns, so a 30-pattern run crosses two seed advances and also wraps the twisted-ring counter back to zero. The short chains keep every shifted bit checkable against a model of the counter and seed. Runs with limits of one and zero reach the end-of-test path at its smallest cases.

// File: rtl/msic_pkg.sv
package msic_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_STEP,
    ST_SHIFT,
    ST_CAPT,
    ST_DONE
  } tpg_state_e;
endpackage

// File: rtl/msic_seed_lfsr.sv
module msic_seed_lfsr #(
  parameter int unsigned         W    = 8,
  parameter logic [W-1:0]        TAPS = 8'hB8,
  parameter logic [W-1:0]        INIT = 8'h01
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb  = ^(q & TAPS);
  assign q_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= INIT;
    else if (step_i) q <= {q[W-2:0], fb};
  end

  // R6
  seed_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o != '0);
  // R6
  seed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(q_o));
endmodule

// File: rtl/msic_johnson.sv
module msic_johnson #(
  parameter int unsigned L = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         mode_i,   // 1: rotate / clear, 0: twisted step
  input  logic         init_i,   // with mode_i=1: 1 rotate, 0 clear
  output logic [L-1:0] q_o
);
  logic [L-1:0] q;
  logic [L-1:0] q_nxt;

  always_comb begin
    if (!mode_i)     q_nxt = {q[L-2:0], ~q[L-1]};
    else if (init_i) q_nxt = {q[L-2:0], q[L-1]};
    else             q_nxt = {q[L-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= q_nxt;
  end

  assign q_o = q;

  // R3
  jc_step_sic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !mode_i |=> $countones(q_o ^ $past(q_o)) == 1);
  // R4
  jc_rot_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i && init_i |=> $countones(q_o) == $countones($past(q_o)));
  // R2
  jc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i && !init_i |=> !q_o[0]);
endmodule

// File: rtl/msic_ctrl.sv
module msic_ctrl
  import msic_pkg::*;
#(
  parameter int unsigned L      = 8,
  parameter int unsigned PCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PCNT_W-1:0] pat_limit_i,
  output logic              jc_en_o,
  output logic              jc_mode_o,
  output logic              jc_init_o,
  output logic              seed_step_o,
  output logic              shift_o,
  output logic              capt_o,
  output logic              done_o
);
  localparam int unsigned BW = $clog2(L + 1);
  localparam int unsigned VW = $clog2(2 * L);

  tpg_state_e        state;
  logic [BW-1:0]     bit_cnt;
  logic [VW-1:0]     vec_cnt;
  logic [PCNT_W-1:0] pat_cnt;
  logic [PCNT_W-1:0] pat_nxt;
  logic              vec_last;

  assign pat_nxt  = pat_cnt + 1'b1;
  assign vec_last = (vec_cnt == VW'(2 * L - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_CLEAR;
      bit_cnt <= '0;
      vec_cnt <= '0;
      pat_cnt <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          if (bit_cnt == BW'(L)) begin
            bit_cnt <= '0;
            state   <= (pat_limit_i == '0) ? ST_DONE : ST_STEP;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_STEP: state <= ST_SHIFT;
        ST_SHIFT: begin
          if (bit_cnt == BW'(L - 1)) begin
            bit_cnt <= '0;
            state   <= ST_CAPT;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_CAPT: begin
          pat_cnt <= pat_nxt;
          vec_cnt <= vec_last ? '0 : vec_cnt + 1'b1;
          state   <= (pat_nxt == pat_limit_i) ? ST_DONE : ST_STEP;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign jc_en_o     = (state == ST_CLEAR) || (state == ST_STEP) || (state == ST_SHIFT);
  assign jc_mode_o   = (state != ST_STEP);
  assign jc_init_o   = (state == ST_SHIFT);
  assign seed_step_o = (state == ST_CAPT) && vec_last;
  assign shift_o     = (state == ST_SHIFT);
  assign capt_o      = (state == ST_CAPT);
  assign done_o      = (state == ST_DONE);

  // R5
  capt_after_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capt_o |-> $past(state) == ST_SHIFT);
  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/msic_tpg.sv
module msic_tpg #(
  parameter int unsigned              NUM_CHAINS = 4,
  parameter int unsigned              CHAIN_LEN  = 8,
  parameter int unsigned              SEED_W     = 8,
  parameter logic [SEED_W-1:0]        SEED_TAPS  = 8'hB8,
  parameter logic [SEED_W-1:0]        SEED_INIT  = 8'h01,
  parameter int unsigned              PCNT_W     = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PCNT_W-1:0]     pat_limit_i,
  output logic [NUM_CHAINS-1:0] scan_data_o,
  output logic                  shift_o,
  output logic                  scan_en_o,
  output logic                  capture_o,
  output logic                  done_o
);
  logic [CHAIN_LEN-1:0]  jc;
  logic [SEED_W-1:0]     seed;
  logic [NUM_CHAINS-1:0] mix;
  logic jc_en, jc_mode, jc_init, seed_step, shift_c, capt_c, done_c;

  msic_ctrl #(.L(CHAIN_LEN), .PCNT_W(PCNT_W)) ctrl_i (
    .clk_i, .rst_ni, .pat_limit_i,
    .jc_en_o(jc_en), .jc_mode_o(jc_mode), .jc_init_o(jc_init),
    .seed_step_o(seed_step), .shift_o(shift_c), .capt_o(capt_c), .done_o(done_c)
  );

  msic_johnson #(.L(CHAIN_LEN)) jc_i (
    .clk_i, .rst_ni, .en_i(jc_en), .mode_i(jc_mode), .init_i(jc_init), .q_o(jc)
  );

  msic_seed_lfsr #(.W(SEED_W), .TAPS(SEED_TAPS), .INIT(SEED_INIT)) seed_i (
    .clk_i, .rst_ni, .step_i(seed_step), .q_o(seed)
  );

  // chain j taps counter stage j and seed bit j
  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_mix
    assign mix[g] = jc[g] ^ seed[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_data_o <= '0;
      shift_o     <= 1'b0;
      scan_en_o   <= 1'b1;
      capture_o   <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      if (shift_c) scan_data_o <= mix;
      shift_o   <= shift_c;
      scan_en_o <= !capt_c;
      capture_o <= capt_c;
      done_o    <= done_c;
    end
  end

  // R5
  capt_se_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> !scan_en_o && !shift_o);
  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_o |-> $stable(scan_data_o));
  // R7
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !shift_o && !capture_o);
endmodule

// File: tb/msic_tpg_tb_top.sv
module msic_tpg_tb_top;
  localparam int M = 4;
  localparam int L = 6;
  localparam int W = 8;
  localparam logic [W-1:0] TAPS  = 8'hB8;
  localparam logic [W-1:0] SINIT = 8'h01;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  pat_limit = '0;
  logic [M-1:0] scan_data;
  logic         shift, scan_en, capture, done;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  msic_tpg #(.NUM_CHAINS(M), .CHAIN_LEN(L), .SEED_W(W), .SEED_TAPS(TAPS),
             .SEED_INIT(SINIT), .PCNT_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pat_limit_i(pat_limit),
    .scan_data_o(scan_data), .shift_o(shift), .scan_en_o(scan_en),
    .capture_o(capture), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] jstep(input logic [L-1:0] v);
    return {v[L-2:0], ~v[L-1]};
  endfunction

  function automatic logic [L-1:0] jrot(input logic [L-1:0] v);
    return {v[L-2:0], v[L-1]};
  endfunction

  function automatic logic [W-1:0] sadv(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  // one run: reset, then follow every output cycle against the model
  task automatic run_case(input int limit);
    logic [L-1:0] jm, rot, cw, prev_cw;
    logic [W-1:0] sm;
    logic [M-1:0] last_data;
    bit prev_ok, first;
    int bitk, pats;
    pat_limit = 16'(limit);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(scan_data == '0 && !shift && scan_en && !capture && !done, "R1",
        {scan_data, shift, scan_en, capture, done}, 8'h04);
    rst_n = 1'b1;
    jm = '0; rot = '0; cw = '0; prev_cw = '0; sm = SINIT;
    prev_ok = 0; first = 1; bitk = 0; pats = 0; last_data = '0;
    for (int c = 0; c < (limit + 2) * (L + 3) + 20; c++) begin
      @(negedge clk);
      if (shift) begin
        if (bitk == 0) begin
          jm = jstep(jm);
          rot = jm;
          // R2
          if (first) chk(jm == L'(1), "R2", int'(jm), 1);
          first = 0;
        end
        // R4
        chk(scan_data == (rot[M-1:0] ^ sm[M-1:0]), "R4", int'(scan_data),
            int'(rot[M-1:0] ^ sm[M-1:0]));
        cw[bitk % L] = scan_data[0];
        rot = jrot(rot);
        bitk++;
      end else begin
        // R9
        chk(scan_data == last_data, "R9", int'(scan_data), int'(last_data));
      end
      if (capture) begin
        // R5
        chk(bitk == L && !scan_en, "R5", bitk, L);
        bitk = 0;
        pats++;
        // R8
        if (prev_ok) chk($countones(cw ^ prev_cw) == 1, "R8", int'(cw), int'(prev_cw));
        prev_cw = cw;
        prev_ok = 1;
        if (pats % (2 * L) == 0) begin
          // R6 / R3: seed moves after 2L patterns, counter back at zero
          chk(jm == '0, "R3", int'(jm), 0);
          sm = sadv(sm);
          chk(sm != '0, "R6", int'(sm), 1);
          prev_ok = 0;
        end
      end else begin
        // R5
        chk(scan_en, "R5", int'(scan_en), 1);
      end
      last_data = scan_data;
      if (done) break;
    end
    // R7
    chk(done, "R7", int'(done), 1);
    chk(pats == limit, "R7", pats, limit);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      // R7
      chk(done && !shift && !capture && scan_en, "R7",
          {done, shift, capture, scan_en}, 4'h9);
    end
  endtask

  task automatic t_long;   run_case(30); endtask
  task automatic t_single; run_case(1);  endtask
  task automatic t_zero;   run_case(0);  endtask

  initial begin
    t_long();
    t_single();
    t_zero();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule